// File: doc/BRIEF.md
# Triggered Circular Trace Capture Buffer

This block records a stream of trace frames into an internal RAM used as a ring. Each accepted frame goes through a short ingress pipeline and is then written at the write pointer. The pointer wraps modulo the RAM depth, so the buffer always holds the most recent frames. Capture is normally left running until a frame marked as a trigger arrives. After that, a post-trigger counter sets how many more frames are stored before capture stops. The value loaded into the counter therefore fixes how much history is kept on each side of the trigger.

Software drives everything through a small register port: a strobe, a read/write select, a 3-bit address and 32-bit write data, with registered read data. The usual sequence has four steps. Software clears the write pointer, loads the post-trigger count, sets the enable bit and then polls status. It then unloads the capture through the RAM-data register, which returns the word at the read pointer and steps the pointer forward. If the wrapped flag is set, the oldest valid frame sits at the write pointer. If it is not set, the valid frames occupy slots 0 up to the write pointer minus one.

Register map: address 0 RAM depth (read-only), 1 frame width in bits (read-only), 2 status (read-only), 3 control, 4 RAM data (read-only, auto-advancing), 5 read pointer, 6 write pointer, 7 post-trigger count.

Top module: `trace_capture_buf`

## Requirements
- R1: After reset, status, control, read pointer, write pointer and post-trigger count all read as 0.
- R2: Address 0 reads the RAM depth (default 16) and address 1 reads the frame width in bits (default 24).
- R3: While control bit 0 is 1, each cycle with frameValid high stores frameData at the write pointer. The write lands PIPE_STAGES clock edges after the frame is sampled, and the write pointer then steps by one modulo the depth. Frames offered while control bit 0 is 0 are not stored and leave the write pointer unchanged.
- R4: Status bit 0 (wrapped) becomes 1 when a frame is stored in the last slot (depth-1). It stays at 1 until enable is switched from 0 to 1.
- R5: Status bit 1 (triggered) becomes 1 when a frame offered with frameTrig high is stored. The trigger flag itself is not stored in the RAM.
- R6: The post-trigger count (address 7, read/write) decreases by one for each frame stored after the trigger frame. Once it is 0 it holds at 0.
- R7: Status bit 2 (complete) becomes 1 when a stored frame leaves the count at 0 with the trigger seen. With a count of 0, this happens on the trigger frame itself. After that no frame is stored and the write pointer holds.
- R8: Status bit 3 (drained) is 1 exactly when status bit 2 is 1 and the ingress pipeline holds no frame. Once set, it stays set until control is written.
- R9: Each read of address 4 returns the stored frame at the read pointer, zero-extended to 32 bits, and then steps the read pointer by one modulo the depth. Address 5 reads and writes the read pointer.
- R10: A control write that changes bit 0 from 0 to 1 clears status bits 0, 1 and 2.
- R11: Control bit 1 (demultiplexed port mode) reads back as written when PORT_BITS is 8. With any other port width, a control write that sets bit 1 is dropped as a whole.
- R12: Read data appears on regRdata one clock edge after a read strobe and holds its value until the next read.
- R13: Address 6 reads and writes the write pointer. A software write takes priority over a capture write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameValid | input | 1 | A trace frame is offered this cycle |
| frameData | input | FRAME_W | Trace frame payload |
| frameTrig | input | 1 | The offered frame is the trigger frame |
| regEn | input | 1 | Register access strobe |
| regWrite | input | 1 | 1 for write, 0 for read |
| regAddr | input | 3 | Register address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Registered read data |

## Verification
Register read data is due one edge after the read strobe. The bench queues the expected word when it drives the strobe, and the monitor pops that word and compares it 2 ns after the following rising edge. A frame reaches the RAM and moves the pointers and flags PIPE_STAGES edges after it is sampled. Completion of capture also has to be followed by the ingress pipeline emptying before the drained flag rises. For these reasons the bench idles several cycles after every burst of frames before it reads pointers or status. The wrap of both pointers, a zero post-trigger count, and frames dropped after completion or while disabled are each given their own sequence.

// File: rtl/trace_capture_pkg.sv
package trace_capture_pkg;

  typedef enum logic [2:0] {
    ADDR_DEPTH  = 3'd0,
    ADDR_WIDTH  = 3'd1,
    ADDR_STATUS = 3'd2,
    ADDR_CTRL   = 3'd3,
    ADDR_DATA   = 3'd4,
    ADDR_RDPTR  = 3'd5,
    ADDR_WRPTR  = 3'd6,
    ADDR_COUNT  = 3'd7
  } tcAddr_e;

  // status bit positions (software decodes these)
  localparam int ST_WRAPPED   = 0;
  localparam int ST_TRIGGERED = 1;
  localparam int ST_COMPLETE  = 2;
  localparam int ST_DRAINED   = 3;

  // control -> datapath strobes
  typedef struct packed {
    logic pipeAccept;
    logic ramWrite;
    logic wrPtrLoad;
    logic rdPtrLoad;
    logic rdPtrInc;
    logic rdLatch;
  } tcStrobe_t;

endpackage

// File: rtl/trace_capture_ctrl.sv
module trace_capture_ctrl
  import trace_capture_pkg::*;
#(
  parameter int PORT_BITS = 8,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regEn,
  input  logic             regWrite,
  input  logic [2:0]       regAddr,
  input  logic [31:0]      regWdata,
  input  logic             frameValid,
  input  logic             pipeOutValid,
  input  logic             pipeOutTrig,
  input  logic             pipeEmpty,
  input  logic             wrPtrAtLast,
  output tcStrobe_t        strobe,
  output logic [1:0]       ctrlBits,
  output logic [3:0]       statusBits,
  output logic [CNT_W-1:0] trigCount
);

  localparam bit DEMUX_LEGAL = (PORT_BITS == 8);

  logic enable, demux, wrapped, triggered, complete;
  logic regWr, regRd, ctrlWr, demuxOk, enableRise, countWr;
  logic trigSeen, countDec;
  logic [CNT_W-1:0] nextCount;
  logic unusedWdata;

  assign unusedWdata = ^regWdata[31:CNT_W];

  assign regWr      = regEn & regWrite;
  assign regRd      = regEn & ~regWrite;
  assign ctrlWr     = regWr && (regAddr == ADDR_CTRL);
  assign demuxOk    = DEMUX_LEGAL || !regWdata[1];
  assign enableRise = ctrlWr && demuxOk && regWdata[0] && !enable;
  assign countWr    = regWr && (regAddr == ADDR_COUNT);

  always_comb begin
    strobe            = '0;
    strobe.pipeAccept = frameValid && enable && !complete;
    strobe.ramWrite   = pipeOutValid && !complete;
    strobe.wrPtrLoad  = regWr && (regAddr == ADDR_WRPTR);
    strobe.rdPtrLoad  = regWr && (regAddr == ADDR_RDPTR);
    strobe.rdPtrInc   = regRd && (regAddr == ADDR_DATA);
    strobe.rdLatch    = regRd;
  end

  assign trigSeen  = strobe.ramWrite && (triggered || pipeOutTrig);
  assign countDec  = strobe.ramWrite && triggered && (trigCount != '0);
  assign nextCount = countDec ? trigCount - 1'b1 : trigCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable    <= 1'b0;
      demux     <= 1'b0;
      wrapped   <= 1'b0;
      triggered <= 1'b0;
      complete  <= 1'b0;
      trigCount <= '0;
    end else begin
      if (ctrlWr && demuxOk) begin
        enable <= regWdata[0];
        demux  <= regWdata[1];
      end
      if (enableRise) begin
        wrapped   <= 1'b0;
        triggered <= 1'b0;
        complete  <= 1'b0;
      end else begin
        if (strobe.ramWrite && wrPtrAtLast) wrapped <= 1'b1;
        if (strobe.ramWrite && pipeOutTrig) triggered <= 1'b1;
        if (trigSeen && (nextCount == '0)) complete <= 1'b1;
      end
      if (countWr)       trigCount <= regWdata[CNT_W-1:0];
      else if (countDec) trigCount <= nextCount;
    end
  end

  assign ctrlBits = {demux, enable};

  always_comb begin
    statusBits               = '0;
    statusBits[ST_WRAPPED]   = wrapped;
    statusBits[ST_TRIGGERED] = triggered;
    statusBits[ST_COMPLETE]  = complete;
    statusBits[ST_DRAINED]   = complete && pipeEmpty;
  end

endmodule

// File: rtl/trace_capture_dp.sv
module trace_capture_dp
  import trace_capture_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int FRAME_W     = 24,
  parameter int PIPE_STAGES = 2,
  parameter int CNT_W       = 16,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  tcStrobe_t          strobe,
  input  logic [FRAME_W-1:0] frameData,
  input  logic               frameTrig,
  input  logic [2:0]         regAddr,
  input  logic [31:0]        regWdata,
  input  logic [1:0]         ctrlBits,
  input  logic [3:0]         statusBits,
  input  logic [CNT_W-1:0]   trigCount,
  output logic               pipeOutValid,
  output logic               pipeOutTrig,
  output logic               pipeEmpty,
  output logic               wrPtrAtLast,
  output logic [AW-1:0]      wrPtr,
  output logic [31:0]        regRdata
);

  localparam int LAST = PIPE_STAGES - 1;

  logic [PIPE_STAGES-1:0] pipeVal;
  logic [PIPE_STAGES-1:0] pipeTrg;
  logic [FRAME_W-1:0]     pipeDat [PIPE_STAGES];
  logic [FRAME_W-1:0]     ram [DEPTH];
  logic [AW-1:0]          rdPtr;
  logic [31:0]            readMux;
  logic                   unusedWdata;

  assign unusedWdata = ^regWdata[31:AW];

  // ingress pipeline: valid and trigger carry reset, payload does not
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipeVal <= '0;
      pipeTrg <= '0;
    end else begin
      for (int s = PIPE_STAGES - 1; s > 0; s--) begin
        pipeVal[s] <= pipeVal[s-1];
        pipeTrg[s] <= pipeTrg[s-1];
      end
      pipeVal[0] <= strobe.pipeAccept;
      pipeTrg[0] <= strobe.pipeAccept && frameTrig;
    end
  end

  always_ff @(posedge clk) begin
    for (int s = PIPE_STAGES - 1; s > 0; s--) pipeDat[s] <= pipeDat[s-1];
    pipeDat[0] <= frameData;
  end

  assign pipeOutValid = pipeVal[LAST];
  assign pipeOutTrig  = pipeTrg[LAST];
  assign pipeEmpty    = ~|pipeVal;

  // ring storage
  always_ff @(posedge clk) begin
    if (strobe.ramWrite) ram[wrPtr] <= pipeDat[LAST];
  end

  assign wrPtrAtLast = (wrPtr == AW'(DEPTH - 1));

  function automatic logic [AW-1:0] stepPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.wrPtrLoad)     wrPtr <= regWdata[AW-1:0];
      else if (strobe.ramWrite) wrPtr <= stepPtr(wrPtr);
      if (strobe.rdPtrLoad)     rdPtr <= regWdata[AW-1:0];
      else if (strobe.rdPtrInc) rdPtr <= stepPtr(rdPtr);
    end
  end

  always_comb begin
    readMux = '0;
    case (regAddr)
      ADDR_DEPTH:  readMux = 32'(DEPTH);
      ADDR_WIDTH:  readMux = 32'(FRAME_W);
      ADDR_STATUS: readMux[3:0] = statusBits;
      ADDR_CTRL:   readMux[1:0] = ctrlBits;
      ADDR_DATA:   readMux[FRAME_W-1:0] = ram[rdPtr];
      ADDR_RDPTR:  readMux[AW-1:0] = rdPtr;
      ADDR_WRPTR:  readMux[AW-1:0] = wrPtr;
      default:     readMux[CNT_W-1:0] = trigCount;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               regRdata <= '0;
    else if (strobe.rdLatch) regRdata <= readMux;
  end

endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf
  import trace_capture_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int FRAME_W     = 24,
  parameter int PIPE_STAGES = 2,
  parameter int PORT_BITS   = 8,
  parameter int CNT_W       = 16,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameValid,
  input  logic [FRAME_W-1:0] frameData,
  input  logic               frameTrig,
  input  logic               regEn,
  input  logic               regWrite,
  input  logic [2:0]         regAddr,
  input  logic [31:0]        regWdata,
  output logic [31:0]        regRdata
);

  tcStrobe_t        strobe;
  logic [1:0]       ctrlBits;
  logic [3:0]       statusBits;
  logic [CNT_W-1:0] trigCount;
  logic [AW-1:0]    wrPtr;
  logic             pipeOutValid, pipeOutTrig, pipeEmpty, wrPtrAtLast;

  trace_capture_ctrl #(
    .PORT_BITS (PORT_BITS),
    .CNT_W     (CNT_W)
  ) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .regEn        (regEn),
    .regWrite     (regWrite),
    .regAddr      (regAddr),
    .regWdata     (regWdata),
    .frameValid   (frameValid),
    .pipeOutValid (pipeOutValid),
    .pipeOutTrig  (pipeOutTrig),
    .pipeEmpty    (pipeEmpty),
    .wrPtrAtLast  (wrPtrAtLast),
    .strobe       (strobe),
    .ctrlBits     (ctrlBits),
    .statusBits   (statusBits),
    .trigCount    (trigCount)
  );

  trace_capture_dp #(
    .DEPTH       (DEPTH),
    .FRAME_W     (FRAME_W),
    .PIPE_STAGES (PIPE_STAGES),
    .CNT_W       (CNT_W)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .frameData    (frameData),
    .frameTrig    (frameTrig),
    .regAddr      (regAddr),
    .regWdata     (regWdata),
    .ctrlBits     (ctrlBits),
    .statusBits   (statusBits),
    .trigCount    (trigCount),
    .pipeOutValid (pipeOutValid),
    .pipeOutTrig  (pipeOutTrig),
    .pipeEmpty    (pipeEmpty),
    .wrPtrAtLast  (wrPtrAtLast),
    .wrPtr        (wrPtr),
    .regRdata     (regRdata)
  );

endmodule

// File: rtl/trace_capture_chk.sv
module trace_capture_chk
  import trace_capture_pkg::*;
#(
  parameter int AW    = 4,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             regEn,
  input logic             regWrite,
  input logic [2:0]       regAddr,
  input logic [31:0]      regRdata,
  input logic [3:0]       statusBits,
  input logic [AW-1:0]    wrPtr,
  input logic [CNT_W-1:0] trigCount
);

  logic anyWrite, ctrlWrite, countWrite, anyRead;
  assign anyWrite   = regEn && regWrite;
  assign ctrlWrite  = anyWrite && (regAddr == ADDR_CTRL);
  assign countWrite = anyWrite && (regAddr == ADDR_COUNT);
  assign anyRead    = regEn && !regWrite;

  // R4: the wrapped flag is sticky until control is written
  assert_wrapped_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    (statusBits[ST_WRAPPED] && !ctrlWrite) |=> statusBits[ST_WRAPPED]);

  // R6: the count never wraps below zero
  assert_count_holds_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (trigCount == '0 && !countWrite) |=> (trigCount == '0));

  // R7: completion implies a trigger was seen
  assert_complete_after_trigger_R7: assert property (@(posedge clk) disable iff (!rstN)
    statusBits[ST_COMPLETE] |-> statusBits[ST_TRIGGERED]);

  // R7: no frame is stored once capture has completed
  assert_complete_freezes_wrptr_R7: assert property (@(posedge clk) disable iff (!rstN)
    (statusBits[ST_COMPLETE] && !anyWrite) |=> $stable(wrPtr));

  // R8: once drained, nothing re-enters the pipeline until control changes
  assert_drained_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (statusBits[ST_DRAINED] && !ctrlWrite) |=> statusBits[ST_DRAINED]);

  // R12: read data only moves on a read strobe
  assert_rdata_holds_R12: assert property (@(posedge clk) disable iff (!rstN)
    !anyRead |=> $stable(regRdata));

endmodule

bind trace_capture_buf trace_capture_chk #(
  .AW    (AW),
  .CNT_W (CNT_W)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .regEn      (regEn),
  .regWrite   (regWrite),
  .regAddr    (regAddr),
  .regRdata   (regRdata),
  .statusBits (statusBits),
  .wrPtr      (wrPtr),
  .trigCount  (trigCount)
);

// File: tb/trace_capture_buf_tb_top.sv
`timescale 1ns/1ps
module trace_capture_buf_tb_top;

  localparam int DEPTH   = 16;
  localparam int FRAME_W = 24;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               frameValid = 1'b0;
  logic [FRAME_W-1:0] frameData = '0;
  logic               frameTrig = 1'b0;
  logic               regEn = 1'b0;
  logic               regWrite = 1'b0;
  logic [2:0]         regAddr = '0;
  logic [31:0]        regWdata = '0;
  logic [31:0]        regRdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  trace_capture_buf dut_i (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .frameData(frameData),
    .frameTrig(frameTrig), .regEn(regEn), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata)
  );

  task automatic checkVal(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regEn = 1'b1; regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regEn = 1'b0; regWrite = 1'b0;
  endtask

  // driver: queue the expected word, then strobe the read
  task automatic regRd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    regEn = 1'b1; regWrite = 1'b0; regAddr = a;
    @(negedge clk);
    regEn = 1'b0;
  endtask

  task automatic sendFrames(input int n, input logic [FRAME_W-1:0] base, input int trigIdx);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frameValid = 1'b1;
      frameData  = base + FRAME_W'(i);
      frameTrig  = (i == trigIdx);
    end
    @(negedge clk);
    frameValid = 1'b0;
    frameTrig  = 1'b0;
  endtask

  // monitor: compare read data one edge after each read strobe
  initial begin
    forever begin
      @(posedge clk);
      if (rstN && regEn && !regWrite) begin
        #2;
        if (expQ.size() == 0) begin
          checks++; errors++;
          $display("FAIL R12: read data 0x%08h with no expected item", regRdata);
        end else begin
          checkVal(tagQ.pop_front(), regRdata, expQ.pop_front());
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);

    // reset state
    regRd(3'd2, 32'h0, "R1 status");
    regRd(3'd3, 32'h0, "R1 control");
    regRd(3'd6, 32'h0, "R1 wrPtr");
    regRd(3'd5, 32'h0, "R1 rdPtr");
    regRd(3'd7, 32'h0, "R1 count");
    regRd(3'd0, 32'd16, "R2 depth");
    regRd(3'd1, 32'd24, "R2 width");

    // frames while disabled are dropped
    sendFrames(3, 24'h0AA000, -1);
    idle(4);
    regRd(3'd6, 32'h0, "R3 disabled wrPtr");
    regRd(3'd2, 32'h0, "R3 disabled status");

    // arm with count 3 and capture pre-trigger history
    regWr(3'd7, 32'd3);
    regWr(3'd6, 32'd0);
    regWr(3'd3, 32'd1);
    regRd(3'd7, 32'd3, "R6 count load");
    sendFrames(5, 24'h000100, -1);
    idle(4);
    regRd(3'd6, 32'd5, "R3 wrPtr after 5");
    regRd(3'd2, 32'h0, "R5 no trigger yet");

    // trigger then three more frames; the rest are dropped
    sendFrames(6, 24'h000200, 0);
    idle(6);
    regRd(3'd6, 32'd9, "R7 wrPtr at completion");
    regRd(3'd2, 32'hE, "R8 status triggered complete drained");
    regRd(3'd7, 32'd0, "R6 count exhausted");
    sendFrames(2, 24'h000900, -1);
    idle(4);
    regRd(3'd6, 32'd9, "R7 wrPtr frozen");

    // unload around the trigger
    regWr(3'd5, 32'd5);
    regRd(3'd4, 32'h000200, "R9 data trigger frame R5");
    regRd(3'd4, 32'h000201, "R9 data +1");
    regRd(3'd4, 32'h000202, "R9 data +2");
    regRd(3'd4, 32'h000203, "R9 data +3");
    regRd(3'd5, 32'd9, "R9 rdPtr advanced");

    // re-arm, wrap the ring
    regWr(3'd3, 32'd0);
    regRd(3'd2, 32'hE, "R10 flags kept while disabled");
    regWr(3'd7, 32'd20);
    regWr(3'd6, 32'd14);
    regRd(3'd6, 32'd14, "R13 wrPtr load");
    regWr(3'd3, 32'd1);
    regRd(3'd2, 32'h0, "R10 flags cleared on enable");
    sendFrames(4, 24'h000300, -1);
    idle(4);
    regRd(3'd6, 32'd2, "R3 wrPtr wrapped");
    regRd(3'd2, 32'h1, "R4 wrapped flag");
    regRd(3'd7, 32'd20, "R6 no decrement before trigger");
    regWr(3'd5, 32'd14);
    regRd(3'd4, 32'h000300, "R9 slot 14");
    regRd(3'd4, 32'h000301, "R9 slot 15");
    regRd(3'd4, 32'h000302, "R9 wrap slot 0");
    regRd(3'd4, 32'h000303, "R9 slot 1");
    regRd(3'd5, 32'd2, "R9 rdPtr wrapped");
    idle(3);
    checkVal("R12 read data held", regRdata, 32'd2);
    sendFrames(2, 24'h000400, -1);
    idle(4);
    regRd(3'd2, 32'h1, "R4 wrapped sticky");

    // demux mode bit with an 8-bit port
    regWr(3'd3, 32'd3);
    regRd(3'd3, 32'd3, "R11 demux accepted");
    regWr(3'd3, 32'd0);
    regRd(3'd3, 32'd0, "R11 control cleared");

    // zero count: completion on the trigger frame itself
    regWr(3'd7, 32'd0);
    regWr(3'd6, 32'd0);
    regWr(3'd3, 32'd1);
    sendFrames(3, 24'h000500, 1);
    idle(6);
    regRd(3'd6, 32'd2, "R7 zero count wrPtr");
    regRd(3'd2, 32'hE, "R7 zero count status");
    regWr(3'd5, 32'd1);
    regRd(3'd4, 32'h000501, "R5 trigger frame stored plain");

    idle(4);
    done = 1'b1;
    if (expQ.size() != 0) begin
      checks++; errors++;
      $display("FAIL R12: %0d reads never returned, got 0 expected 0", expQ.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule